// File: doc/BRIEF.md
# SPI Frame Sender with Latch Strobe

This block is an SPI master transmitter that only sends. It fills an external 112-bit shift register, for example one that drives a display, with fixed frames of fourteen bytes. After each frame it pulls an active-low latch line low so that the external register moves its contents to its outputs. Bytes arrive through a one-entry holding buffer with a valid/ready handshake. A shifter drives SCK in mode 0 (idle low) and drives MOSI most significant bit first.

There are two status outputs. `txe` reports that the holding buffer is empty, and it rises while the byte just moved into the shifter is still going out. `bsy` reports that the shifter is active. The latch is timed from the end of shifting, not from `txe`. It fires once per frame, after the last SCK period of the fourteenth byte has finished. A one-cycle `frame_done` marks the end of each latch pulse.

Top module: `spi_frame_latch`

## Requirements
- R1: After a synchronous reset, `sck`=0, `mosi`=0, `latch_n`=1, `txe`=1, `bsy`=0, `in_ready`=1 and `frame_done`=0.
- R2: MOSI changes only while SCK is low. When the value on MOSI is sampled at each SCK rising edge, it reproduces each accepted byte with bit 7 first. Bytes go out in the order they were accepted.
- R3: One SCK period lasts 2*CLK_DIV system clocks. When the holding buffer is refilled before the current byte ends, successive SCK rising edges inside a frame are exactly 2*CLK_DIV clocks apart, with no gap between bytes.
- R4: `txe` is low exactly while the holding buffer holds a byte. It rises when that byte enters the shifter, while `bsy` is still high. `in_ready` equals `txe` outside a latch pulse.
- R5: `bsy` is high while a byte is being shifted. SCK is high only while `bsy` is high.
- R6: `latch_n` falls only after the last of 8*FRAME_BYTES SCK rising edges, in the cycle that `bsy` falls. At the instant `txe` rises for the fourteenth byte, only 104 bits have been clocked out, so a latch timed from `txe` would be early.
- R7: A latch pulse holds `latch_n` low for LATCH_CYCLES clocks. During the pulse, SCK stays low and `in_ready` is 0, so no byte is accepted.
- R8: `frame_done` is high for exactly one cycle, the first cycle after `latch_n` returns high. The byte count then restarts from zero. A reset in the middle of a frame also restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | `in_data` is valid |
| in_ready | output | 1 | Holding buffer can take a byte |
| sck | output | 1 | SPI clock, idle low |
| mosi | output | 1 | Serial data, MSB first |
| latch_n | output | 1 | Active-low latch strobe |
| txe | output | 1 | Holding buffer empty |
| bsy | output | 1 | Shifter active |
| frame_done | output | 1 | One-cycle pulse at the end of the latch pulse |

## Verification
The hardest case to reach is a byte for the next frame already waiting in the holding buffer when the fourteenth byte finishes. The latch must win, and that waiting byte must stay blocked until the pulse ends. The bench creates this case by feeding frames back to back with `in_valid` held high, so the first byte of the next frame enters the buffer during the last byte of the current one. The early-`txe` hazard is measured directly: the bench counts the bits the emulated slave has received at the moment `txe` rises for the fourteenth byte. A mid-frame reset checks that the count restarts.

// File: rtl/spi_frame_latch.sv
module spi_frame_latch #(
  parameter int CLK_DIV      = 2,
  parameter int FRAME_BYTES  = 14,
  parameter int LATCH_CYCLES = 2,
  parameter int DW           = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  output logic          in_ready,
  output logic          sck,
  output logic          mosi,
  output logic          latch_n,
  output logic          txe,
  output logic          bsy,
  output logic          frame_done
);
  localparam int DIV_W = $clog2(CLK_DIV + 1);
  localparam int CNT_W = $clog2(FRAME_BYTES + 1);
  localparam int LAT_W = $clog2(LATCH_CYCLES + 1);
  localparam int BIT_W = $clog2(DW);

  logic             hold_full, shifting, sck_q, done_q;
  logic [DW-1:0]    hold_data, shreg;
  logic [BIT_W-1:0] bitn;
  logic [DIV_W-1:0] div;
  logic [CNT_W-1:0] byte_cnt;
  logic [LAT_W-1:0] lat_cnt;

  wire latching  = lat_cnt != '0;
  wire accept    = in_valid && in_ready;
  wire tick      = shifting && (div == DIV_W'(CLK_DIV - 1));
  wire byte_end  = tick && sck_q && (bitn == BIT_W'(DW - 1));
  wire last_byte = byte_cnt == CNT_W'(FRAME_BYTES - 1);
  wire load      = hold_full && !latching && (!shifting || (byte_end && !last_byte));

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_full <= 1'b0;
      hold_data <= '0;
      shifting  <= 1'b0;
      shreg     <= '0;
      bitn      <= '0;
      div       <= '0;
      sck_q     <= 1'b0;
      byte_cnt  <= '0;
      lat_cnt   <= '0;
      done_q    <= 1'b0;
    end else begin
      if (accept) begin
        hold_full <= 1'b1;
        hold_data <= in_data;
      end else if (load) begin
        hold_full <= 1'b0;
      end

      if (!shifting || load || tick) div <= '0;
      else                           div <= div + 1'b1;

      if (load) begin
        shifting <= 1'b1;
        shreg    <= hold_data;
        bitn     <= '0;
        sck_q    <= 1'b0;
      end else if (tick) begin
        if (!sck_q) begin
          sck_q <= 1'b1;
        end else begin
          sck_q <= 1'b0;
          if (bitn == BIT_W'(DW - 1)) shifting <= 1'b0;
          else begin
            shreg <= shreg << 1;
            bitn  <= bitn + 1'b1;
          end
        end
      end

      if (lat_cnt == LAT_W'(1))           byte_cnt <= '0;
      else if (byte_end && !last_byte)    byte_cnt <= byte_cnt + 1'b1;

      if (byte_end && last_byte) lat_cnt <= LAT_W'(LATCH_CYCLES);
      else if (latching)         lat_cnt <= lat_cnt - 1'b1;

      done_q <= lat_cnt == LAT_W'(1);
    end
  end

  assign in_ready   = !hold_full && !latching;
  assign txe        = !hold_full;
  assign bsy        = shifting;
  assign sck        = sck_q;
  assign mosi       = shifting && shreg[DW-1];
  assign latch_n    = !latching;
  assign frame_done = done_q;

  // R2
  mosi_hold_chk: assert property (@(posedge clk) disable iff (rst) sck |-> $stable(mosi));
  // R4
  txe_accept_chk: assert property (@(posedge clk) disable iff (rst) (in_valid && in_ready) |=> !txe);
  // R5
  sck_busy_chk: assert property (@(posedge clk) disable iff (rst) sck |-> bsy);
  // R6
  latch_after_shift_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(latch_n) |-> (!bsy && $past(bsy)));
  // R7
  latch_idle_chk: assert property (@(posedge clk) disable iff (rst) !latch_n |-> (!sck && !in_ready));
  // R8
  done_after_latch_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (latch_n && $past(!latch_n)));
endmodule

// File: tb/spi_frame_latch_bench.sv
module spi_frame_latch_bench;
  localparam int CLK_DIV = 2, NB = 14, LATW = 2, NBITS = NB * 8, NFR = 8;

  logic clk = 0, rst = 1, in_valid = 0;
  logic [7:0] in_data = 0;
  logic in_ready, sck, mosi, latch_n, txe, bsy, frame_done;

  spi_frame_latch #(.CLK_DIV(CLK_DIV), .FRAME_BYTES(NB), .LATCH_CYCLES(LATW)) u_spi_frame_latch (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .sck(sck), .mosi(mosi), .latch_n(latch_n), .txe(txe), .bsy(bsy), .frame_done(frame_done));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic [NBITS-1:0] exp_fr [NFR];
  logic [NBITS-1:0] rx;
  int bits_rx = 0, txe_rises = 0, last_rise = 0, gap_bad = 0, latch_len = 0;
  int latched = 0, done_cnt = 0, mon_on = 0, continuous = 0;
  logic sck_q = 0, txe_q = 1, lat_q = 1;

  task automatic chk(input bit ok, input string req, input logic [NBITS-1:0] act, input logic [NBITS-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_of(input int p, input int i);
    case (p)
      0: return 8'(i);
      1: return 8'hFF;
      2: return 8'h00;
      3: return (i % 2) ? 8'h55 : 8'hAA;
      4: return 8'(i * 37 + 5);
      5: return 8'h80 >> (i % 8);
      6: return 8'(255 - i * 3);
      default: return 8'(i * 91 + 17);
    endcase
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (mon_on) begin
      if (sck && !sck_q) begin
        if (continuous && bits_rx > 0 && cyc - last_rise != 2 * CLK_DIV) gap_bad++;
        last_rise = cyc;
        rx = {rx[NBITS-2:0], mosi};
        bits_rx++;
      end
      if (txe && !txe_q) begin
        txe_rises++;
        if (txe_rises == NB) begin
          // R6: a latch timed here would come too early
          chk(bits_rx == NBITS - 8, "R6 bits out at 14th txe rise", bits_rx, NBITS - 8);
          chk(bsy && latch_n, "R4 txe rises while still busy, no latch yet", {bsy, latch_n}, 2'b11);
        end
      end
      if (!latch_n) begin
        latch_len++;
        chk(!sck && !in_ready, "R7 sck idle and in_ready low in latch", {sck, in_ready}, 0);
      end
      if (!latch_n && lat_q) begin
        chk(bits_rx == NBITS, "R6 bit count at latch", bits_rx, NBITS);
        chk(!bsy, "R6 bsy low at latch", bsy, 0);
        chk(rx == exp_fr[latched], "R2 frame content at latch", rx, exp_fr[latched]);
        chk(gap_bad == 0, "R3 sck rise spacing within frame", gap_bad, 0);
        latched++;
        bits_rx = 0; txe_rises = 0; gap_bad = 0;
      end
      if (latch_n && !lat_q) begin
        chk(latch_len == LATW, "R7 latch width", latch_len, LATW);
        chk(frame_done, "R8 frame_done in first cycle after latch", frame_done, 1);
        latch_len = 0;
      end
      if (frame_done) done_cnt++;
      if (frame_done && !(latch_n && !lat_q)) chk(0, "R8 frame_done one cycle only", 1, 0);
    end
    sck_q = sck; txe_q = txe; lat_q = latch_n;
  end

  task automatic send(input logic [7:0] b);
    in_valid = 1; in_data = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    for (int f = 0; f < NFR; f++) begin
      exp_fr[f] = '0;
      for (int i = 0; i < NB; i++) exp_fr[f] = (exp_fr[f] << 8) | NBITS'(byte_of(f, i));
    end
    repeat (3) @(negedge clk);
    // R1
    chk({sck, mosi, latch_n, txe, bsy, in_ready, frame_done} == 7'b0011010,
        "R1 reset state", {sck, mosi, latch_n, txe, bsy, in_ready, frame_done}, 7'b0011010);
    rst = 0;
    // R8: partial frame, then reset mid-frame; the count must restart
    for (int i = 0; i < 5; i++) send(8'hC3);
    repeat (10) @(negedge clk);
    do_reset();
    repeat (2) @(negedge clk);
    chk({latch_n, bsy, txe} == 3'b101, "R8 state after mid-frame reset", {latch_n, bsy, txe}, 3'b101);
    mon_on = 1; continuous = 1;
    for (int f = 0; f < 6; f++)
      for (int i = 0; i < NB; i++) begin
        in_valid = 1; in_data = byte_of(f, i);
        while (!in_ready) @(negedge clk);
        @(negedge clk);
      end
    in_valid = 0;
    while (bsy || !latch_n || latched < 6) @(negedge clk);
    continuous = 0;
    for (int f = 6; f < NFR; f++)
      for (int i = 0; i < NB; i++) begin
        send(byte_of(f, i));
        while (bsy || !txe) @(negedge clk);
        repeat (3) @(negedge clk);
        if (i < NB - 1) chk(latch_n, "R6 no latch before frame end", latch_n, 1);
      end
    repeat (10) @(negedge clk);
    chk(latched == NFR, "R6 one latch per frame", latched, NFR);
    chk(done_cnt == NFR, "R8 frame_done count", done_cnt, NFR);
    chk({bsy, txe, latch_n, sck} == 4'b0110, "R5 idle after last frame", {bsy, txe, latch_n, sck}, 4'b0110);
    finish_run();
  end

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end
endmodule